// File: doc/BRIEF.md
# Divide-by-Twelve Gated Event Timer

This block measures how long a level stays high. While gated mode is on and the selected input is high, a prescaler divides the timer clock by twelve, and a 16-bit counter advances once per twelve clock edges. When the input falls, the count stays where it is, so software can read it at leisure.

Two selectors sit in front of the counter. The input selector normally passes the ordinary timer input. When the calibration select bit is set, it passes the one-period calibration pulse instead, so the count measures one period of the slow oscillator in units of twelve main-clock cycles. At 8 MHz one step is 1.5 µs, and a 32 kHz period gives about twenty steps. The clock selector runs the timer from the main clock, or from the standby clock while the stop signal is high. The selected clock also leaves the block for the watchdog.

Software prepares a measurement in two steps. It pulses the load input, which clears both the counter and the prescaler. It then raises the gated-mode input. That rising mode realigns the prescaler phase to the start of the measurement.

Top module: `gated_timer`

## Requirements
- R1: While rst_ni is low, cnt_o is zero.
- R2: With mode_i high, load_i low and the selected input high, cnt_o rises by exactly one on every twelfth rising edge of the timer clock. The edge that first sees mode_i high does not count, and the first increment comes on the twelfth edge after it.
- R3: cnt_o saturates at all ones. It stays there while counting would continue and never wraps to zero.
- R4: While mode_i is low or the selected input is low, cnt_o holds and the prescaler phase is kept. When counting resumes, the remaining edges of the interrupted twelve-edge step complete it.
- R5: With test_i = 1 the selected input is gate_i and tin_i has no effect. With test_i = 0 the selected input is tin_i and gate_i has no effect.
- R6: An edge with load_i high clears cnt_o and the prescaler phase. This takes priority over an increment due on the same edge, and a full twelve counted edges are then needed for the next increment.
- R7: An edge that sees mode_i high after an edge with mode_i low clears the prescaler phase and does not advance cnt_o. This holds even when part of a step had been counted before.
- R8: The timer clock and clk_o equal clk_main_i while stop_i = 0 and clk_sby_i while stop_i = 1. While stop_i = 1, counting follows standby clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main_i | input | 1 | Main clock |
| clk_sby_i | input | 1 | Standby clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Stop state: selects the standby clock |
| test_i | input | 1 | Calibration select: routes gate_i to the timer input |
| tin_i | input | 1 | Ordinary timer input level |
| gate_i | input | 1 | Calibration gate pulse |
| load_i | input | 1 | Synchronous clear of counter and prescaler |
| mode_i | input | 1 | Gated counting mode enable |
| clk_o | output | 1 | Selected timer and watchdog clock |
| cnt_o | output | CNT_W (16) | Current count |

## Verification
Two events can land on the same edge. A load can coincide with the prescaler's twelfth edge, and a gated-mode entry can coincide with an input that is already high. The bench provokes the first by holding the gate high for exactly eleven edges and raising load on the twelfth. It provokes the second by dropping mode mid-step and raising it again with the input still high. In both cases a per-edge behavioural model decides the expected count, and explicit checks confirm that the next increment needs a full twelve edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CLEAR = 2'd1,
    ACT_ALIGN = 2'd2,
    ACT_RUN   = 2'd3
  } tmr_act_e;
endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel (
  input  logic clk_main_i,
  input  logic clk_sby_i,
  input  logic stop_i,
  output logic clk_o
);
  // stop_i must only change while both clocks are low
  assign clk_o = stop_i ? clk_sby_i : clk_main_i;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     test_i,
  input  logic     tin_i,
  input  logic     gate_i,
  input  logic     load_i,
  input  logic     mode_i,
  output logic     mode_q_o,
  output tmr_act_e act_o
);
  logic mode_q;
  logic sel_in;

  assign sel_in = test_i ? gate_i : tin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end

  always_comb begin
    if (load_i)                   act_o = ACT_CLEAR;
    else if (mode_i && !mode_q)   act_o = ACT_ALIGN;
    else if (mode_i && sel_in)    act_o = ACT_RUN;
    else                          act_o = ACT_HOLD;
  end

  assign mode_q_o = mode_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = run_i && !clr_i;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     phase_q <= '0;
        else if (clr_i)  phase_q <= '0;
        else if (run_i)  phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end

      assign tick_o = run_i && !clr_i && (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  logic         full;

  assign full = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (inc_i && !full)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PSC_DIV = 12
) (
  input  logic             clk_main_i,
  input  logic             clk_sby_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             test_i,
  input  logic             tin_i,
  input  logic             gate_i,
  input  logic             load_i,
  input  logic             mode_i,
  output logic             clk_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic     tmr_clk;
  logic     mode_q;
  tmr_act_e act;
  logic     tick;

  tmr_clk_sel i_clk_sel (
    .clk_main_i (clk_main_i),
    .clk_sby_i  (clk_sby_i),
    .stop_i     (stop_i),
    .clk_o      (tmr_clk)
  );

  tmr_ctrl i_ctrl (
    .clk_i    (tmr_clk),
    .rst_ni   (rst_ni),
    .test_i   (test_i),
    .tin_i    (tin_i),
    .gate_i   (gate_i),
    .load_i   (load_i),
    .mode_i   (mode_i),
    .mode_q_o (mode_q),
    .act_o    (act)
  );

  tmr_prescaler #(.DIV(PSC_DIV)) i_psc (
    .clk_i  (tmr_clk),
    .rst_ni (rst_ni),
    .clr_i  ((act == ACT_CLEAR) || (act == ACT_ALIGN)),
    .run_i  (act == ACT_RUN),
    .tick_o (tick)
  );

  tmr_counter #(.W(CNT_W)) i_cnt (
    .clk_i  (tmr_clk),
    .rst_ni (rst_ni),
    .clr_i  (act == ACT_CLEAR),
    .inc_i  (tick),
    .cnt_o  (cnt_o)
  );

  assign clk_o = tmr_clk;
endmodule

// File: rtl/gated_timer_chk.sv
module gated_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             test_i,
  input logic             tin_i,
  input logic             gate_i,
  input logic             load_i,
  input logic             mode_i,
  input logic             mode_q_i,
  input logic [CNT_W-1:0] cnt_i
);
  logic sel;
  assign sel = test_i ? gate_i : tin_i;

  p_load_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_i == '0));

  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (&cnt_i)) |=> (&cnt_i));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(mode_i && sel)) |=> $stable(cnt_i));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ((cnt_i == $past(cnt_i)) || (cnt_i == $past(cnt_i) + CNT_W'(1))));

  p_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && mode_i && !mode_q_i) |=> $stable(cnt_i));
endmodule

bind gated_timer gated_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i    (clk_o),
  .rst_ni   (rst_ni),
  .test_i   (test_i),
  .tin_i    (tin_i),
  .gate_i   (gate_i),
  .load_i   (load_i),
  .mode_i   (mode_i),
  .mode_q_i (mode_q),
  .cnt_i    (cnt_o)
);

// File: tb/test_gated_timer.sv
`timescale 1ns/100ps
module test_gated_timer;
  localparam int CW   = 8;
  localparam int DIV  = 12;
  localparam int MAXV = (1 << CW) - 1;

  logic clk_main = 1'b0, clk_sby = 1'b0, rst_n = 1'b0;
  logic stop = 1'b0, test = 1'b0, tin = 1'b0, gate = 1'b0, load = 1'b0, mode = 1'b0;
  logic          clk_o;
  logic [CW-1:0] cnt;

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  int    m_cnt = 0, m_psc = 0;
  bit    m_mode_q = 1'b0;
  realtime t0;

  always #2.5 clk_main = ~clk_main;
  always #30  clk_sby  = ~clk_sby;

  wire mclk = stop ? clk_sby : clk_main;

  gated_timer #(.CNT_W(CW), .PSC_DIV(DIV)) i_gated_timer (
    .clk_main_i (clk_main),
    .clk_sby_i  (clk_sby),
    .rst_ni     (rst_n),
    .stop_i     (stop),
    .test_i     (test),
    .tin_i      (tin),
    .gate_i     (gate),
    .load_i     (load),
    .mode_i     (mode),
    .clk_o      (clk_o),
    .cnt_o      (cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, one step per edge of the selected clock
  always @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_psc = 0; m_mode_q = 1'b0;
    end else begin
      bit in_lvl;
      in_lvl = test ? gate : tin;
      if (load) begin
        m_cnt = 0; m_psc = 0;
      end else if (mode && !m_mode_q) begin
        m_psc = 0;
      end else if (mode && in_lvl) begin
        m_psc = m_psc + 1;
        if (m_psc == DIV) begin
          m_psc = 0;
          if (m_cnt < MAXV) m_cnt = m_cnt + 1;
        end
      end
      m_mode_q = mode;
    end
  end

  always @(negedge mclk) begin
    if (cmp_on) chk(int'(cnt) == m_cnt, cur_req, int'(cnt), m_cnt);
  end

  task automatic edges(input int n);
    repeat (n) @(negedge mclk);
  endtask

  // switch only while both clocks are low
  task automatic set_stop(input bit v);
    @(negedge clk_sby);
    #1;
    stop = v;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1
    #12;
    chk(cnt == '0, "R1", int'(cnt), 0);
    edges(3);
    chk(cnt == '0, "R1", int'(cnt), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    edges(2);
    chk(cnt == '0, "R1", int'(cnt), 0);

    // R2: entry edge, then twelve edges per step
    cur_req = "R2";
    mode = 1'b1; tin = 1'b1;
    edges(1);
    edges(11);
    chk(int'(cnt) == 0, "R2", int'(cnt), 0);
    edges(1);
    chk(int'(cnt) == 1, "R2", int'(cnt), 1);
    edges(48);
    chk(int'(cnt) == 5, "R2", int'(cnt), 5);

    // R4: phase kept across a low input
    cur_req = "R4";
    edges(5);
    tin = 1'b0;
    edges(20);
    chk(int'(cnt) == 5, "R4", int'(cnt), 5);
    tin = 1'b1;
    edges(6);
    chk(int'(cnt) == 5, "R4", int'(cnt), 5);
    edges(1);
    chk(int'(cnt) == 6, "R4", int'(cnt), 6);

    // R7: re-entry realigns phase
    cur_req = "R7";
    edges(7);
    mode = 1'b0;
    edges(3);
    mode = 1'b1;
    edges(1);
    edges(11);
    chk(int'(cnt) == 6, "R7", int'(cnt), 6);
    edges(1);
    chk(int'(cnt) == 7, "R7", int'(cnt), 7);

    // R5: calibration select
    cur_req = "R5";
    test = 1'b1; gate = 1'b0;
    edges(30);
    chk(int'(cnt) == 7, "R5", int'(cnt), 7);
    gate = 1'b1; tin = 1'b0;
    edges(24);
    chk(int'(cnt) == 9, "R5", int'(cnt), 9);
    test = 1'b0;
    edges(24);
    chk(int'(cnt) == 9, "R5", int'(cnt), 9);
    test = 1'b1;

    // R6: load on the edge a tick is due
    cur_req = "R6";
    edges(11);
    load = 1'b1;
    edges(1);
    load = 1'b0;
    chk(int'(cnt) == 0, "R6", int'(cnt), 0);
    edges(11);
    chk(int'(cnt) == 0, "R6", int'(cnt), 0);
    edges(1);
    chk(int'(cnt) == 1, "R6", int'(cnt), 1);

    // R8: standby clock
    cur_req = "R8";
    load = 1'b1;
    edges(1);
    load = 1'b0; gate = 1'b0;
    set_stop(1'b1);
    repeat (4) begin
      #7;
      chk(clk_o == clk_sby, "R8", int'(clk_o), int'(clk_sby));
    end
    edges(1);
    gate = 1'b1;
    t0 = $realtime;
    edges(24);
    chk(int'(cnt) == 2, "R8", int'(cnt), 2);
    chk(($realtime - t0) == 24.0 * 60.0, "R8", int'($realtime - t0), 24 * 60);
    gate = 1'b0;
    set_stop(1'b0);
    repeat (4) begin
      #1.3;
      chk(clk_o == clk_main, "R8", int'(clk_o), int'(clk_main));
    end
    edges(1);

    // R3: saturation
    cur_req = "R3";
    load = 1'b1;
    edges(1);
    load = 1'b0; gate = 1'b1;
    edges(MAXV * DIV);
    chk(int'(cnt) == MAXV, "R3", int'(cnt), MAXV);
    edges(40);
    chk(int'(cnt) == MAXV, "R3", int'(cnt), MAXV);
    gate = 1'b0;
    edges(2);
    chk(int'(cnt) == MAXV, "R3", int'(cnt), MAXV);

    finish_run();
  end
endmodule